// File: doc/BRIEF.md
# Atomic Memory Operation Unit

A memory-side unit that lets several requesters share a small word-addressed memory and perform synchronization primitives on it without interference. Each requester port carries an opcode, a word address and a write value. The unit picks one requester per cycle and carries out that request's read-modify-write in a single step. Because only one request reaches the memory in any cycle, no other access can fall between the read and the write of an atomic operation.

The supported operations are plain load and store, swap, test-and-set, fetch-and-increment, and the load-linked/store-conditional pair. A reservation table holds one entry per requester. A write to a reserved word clears every entry that covers that word, so a store-conditional succeeds only when no other write reached its word after the matching load-linked. Locks follow a simple convention: 0 means free and 1 means held. A requester takes a lock by swapping in 1 and getting 0 back, and releases it with a plain store of 0.

Top module: `amu_top`

## Requirements
- R1: After reset every memory word reads 0, no response is pending, no request is accepted until presented, and no reservation exists, so a store-conditional with no load-linked before it fails.
- R2: At most one request is granted per cycle, and `req_ready` is high only for a requester whose `req_valid` is high. Priority rotates: the search starts at the requester after the last one granted, and requester 0 comes first after reset.
- R3: The response for a request granted at a clock edge appears on the following cycle as a single-cycle pulse on that requester's `rsp_valid` bit, with the result on `rsp_data`.
- R4: The 3-bit opcode is coded as follows: 0 load, 1 store, 2 swap, 3 test-and-set, 4 fetch-and-increment, 5 load-linked, 6 store-conditional. A load returns the word and leaves it unchanged. A store writes the write value and returns 0.
- R5: A swap returns the old word and writes the write value.
- R6: A test-and-set returns the old word. It writes 1 only if the old word was 0, and otherwise leaves the word unchanged.
- R7: A fetch-and-increment returns the old word and stores the old word plus one, wrapping to 0 at the all-ones value.
- R8: A load-linked returns the word and records a reservation on its address for that requester. A later load-linked by the same requester replaces the earlier reservation.
- R9: A store-conditional whose requester holds a reservation on the same address writes the value and returns 1. Any other store-conditional writes nothing and returns 0. In both cases the requester's reservation is consumed.
- R10: Any write to a word clears the reservations of all requesters on that word. This covers a store, a swap, a fetch-and-increment, a test-and-set that writes, and a successful store-conditional. Writes to other words leave those reservations in place.
- R11: When two requesters swap 1 into a free lock word in the same cycle, exactly one of them reads 0, and it is the one that rotating priority favours. The other reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Request granted this cycle, one bit per requester |
| req_op | input | NREQ*3 | Opcode of each requester, 3 bits each |
| req_addr | input | NREQ*AW | Word address of each requester |
| req_wdata | input | NREQ*DW | Write value of each requester |
| rsp_valid | output | NREQ | Response pulse, one bit per requester |
| rsp_data | output | DW | Old value, or the store-conditional flag, for the responding requester |

## Verification
A grant is combinational, so `req_ready` is sampled 1 ns after the inputs are driven at the falling edge, within the same cycle. The operation executes at the next rising edge, and its response and its memory write are both due at the falling edge that follows. The bench samples `rsp_valid` and `rsp_data` there and drops `req_valid` at that moment. Read-back loads and store-conditional results are issued as separate requests after that point, so the memory and reservation effects of a write are observed one full request later. One falling edge after each response, the bench checks that the pulse has ended.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6
  } amu_op_e;

  // Write enable of an operation given the old word and the reservation hit.
  function automatic logic op_writes(input logic [OPW-1:0] op, input logic old_zero,
                                     input logic sc_hit);
    case (op)
      OP_STORE, OP_SWAP, OP_FINC: op_writes = 1'b1;
      OP_TAS:                     op_writes = old_zero;
      OP_SC:                      op_writes = sc_hit;
      default:                    op_writes = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/amu_arb.sv
module amu_arb #(
  parameter int NREQ = 4,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt,
  output logic [IW-1:0]   gnt_idx,
  output logic            gnt_any
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int c;
      c = (int'(last_q) + k) % NREQ;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(NREQ - 1);
    else if (gnt_any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/amu_mem.sv
module amu_mem #(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words_q [DEPTH];

  assign rdata = words_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
    end else if (we) begin
      words_q[addr] <= wdata;
    end
  end
endmodule

// File: rtl/amu_resv.sv
module amu_resv #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] addr,
  input  logic          is_ll,
  input  logic          is_sc,
  input  logic          wr,
  output logic          sc_hit
);
  logic [NREQ-1:0] v_q;
  logic [AW-1:0]   a_q [NREQ];

  assign sc_hit = v_q[idx] && (a_q[idx] == addr);

  generate
    for (genvar j = 0; j < NREQ; j++) begin : g_ent
      logic mine;
      assign mine = act && (idx == IW'(j));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[j] <= 1'b0;
          a_q[j] <= '0;
        end else begin
          if (wr && v_q[j] && a_q[j] == addr) v_q[j] <= 1'b0;
          if (mine && is_sc) v_q[j] <= 1'b0;
          if (mine && is_ll) begin
            v_q[j] <= 1'b1;
            a_q[j] <= addr;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/amu_top.sv
module amu_top
  import amu_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  output logic [NREQ-1:0]    req_ready,
  input  logic [NREQ*OPW-1:0] req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [DW-1:0]      rsp_data
);
  logic [NREQ-1:0] gnt;
  logic [IW-1:0]   gnt_idx;
  logic            gnt_any;
  logic [OPW-1:0]  sel_op;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_wdata;
  logic [DW-1:0]   old_word;
  logic            sc_hit;
  logic            op_ll, op_sc, op_tas;
  logic            sc_try, sc_ok;
  logic            mem_we;
  logic [DW-1:0]   mem_wdata;
  logic [DW-1:0]   result;

  amu_arb #(.NREQ(NREQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  assign req_ready = gnt;
  assign sel_op    = req_op[gnt_idx*OPW +: OPW];
  assign sel_addr  = req_addr[gnt_idx*AW +: AW];
  assign sel_wdata = req_wdata[gnt_idx*DW +: DW];

  assign op_ll  = gnt_any && sel_op == OP_LL;
  assign op_sc  = gnt_any && sel_op == OP_SC;
  assign op_tas = gnt_any && sel_op == OP_TAS;
  assign sc_try = op_sc;
  assign sc_ok  = op_sc && sc_hit;
  assign mem_we = gnt_any && op_writes(sel_op, old_word == '0, sc_hit);

  always_comb begin
    case (sel_op)
      OP_TAS:  mem_wdata = DW'(1);
      OP_FINC: mem_wdata = old_word + DW'(1);
      default: mem_wdata = sel_wdata;
    endcase
    case (sel_op)
      OP_STORE: result = '0;
      OP_SC:    result = DW'(sc_hit);
      default:  result = old_word;
    endcase
  end

  amu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(sel_addr), .we(mem_we),
    .wdata(mem_wdata), .rdata(old_word)
  );

  amu_resv #(.NREQ(NREQ), .AW(AW)) u_resv (
    .clk(clk), .rst_n(rst_n), .act(gnt_any), .idx(gnt_idx), .addr(sel_addr),
    .is_ll(op_ll), .is_sc(op_sc), .wr(mem_we), .sc_hit(sc_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= gnt;
      if (gnt_any) rsp_data <= result;
    end
  end
endmodule

// File: rtl/amu_check.sv
module amu_check #(
  parameter int NREQ = 4,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] gnt,
  input logic            gnt_any,
  input logic [NREQ-1:0] rsp_valid,
  input logic [DW-1:0]   rsp_data,
  input logic            sc_try,
  input logic            sc_ok,
  input logic            op_tas,
  input logic [DW-1:0]   old_word,
  input logic            mem_we
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req_valid) == '0); // R2
  AST_RSP_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) gnt_any |=> rsp_valid == $past(gnt)); // R3
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !gnt_any |=> rsp_valid == '0); // R3
  AST_TAS_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (op_tas && old_word != '0) |-> !mem_we); // R6
  AST_SC_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (sc_try && !sc_ok) |-> !mem_we); // R9
  AST_SC_FLAG_BINARY: assert property (@(posedge clk) disable iff (!rst_n) sc_try |=> rsp_data <= DW'(1)); // R9
endmodule

bind amu_top amu_check #(.NREQ(NREQ), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .gnt(gnt), .gnt_any(gnt_any),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sc_try(sc_try), .sc_ok(sc_ok),
  .op_tas(op_tas), .old_word(old_word), .mem_we(mem_we)
);

// File: tb/amu_top_bench.sv
`timescale 1ns/1ps
module amu_top_bench;
  localparam int NREQ = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int OPW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]     req_valid = '0;
  logic [NREQ-1:0]     req_ready;
  logic [NREQ*OPW-1:0] req_op = '0;
  logic [NREQ*AW-1:0]  req_addr = '0;
  logic [NREQ*DW-1:0]  req_wdata = '0;
  logic [NREQ-1:0]     rsp_valid;
  logic [DW-1:0]       rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  int last_id = NREQ - 1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  amu_top #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_amu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int id, input int op, input int addr, input int wd);
    req_valid[id] = 1'b1;
    req_op[id*OPW +: OPW] = OPW'(op);
    req_addr[id*AW +: AW] = AW'(addr);
    req_wdata[id*DW +: DW] = DW'(wd);
  endtask

  task automatic do_op(input int id, input int op, input int addr, input int wd,
                       output logic [DW-1:0] r);
    @(negedge clk);
    chk("R3 pulse ended", 32'(rsp_valid), 0);
    put(id, op, addr, wd);
    #1 chk("R2 single grant", 32'(req_ready), 32'(1 << id));
    @(negedge clk);
    chk("R3 response", 32'(rsp_valid), 32'(1 << id));
    r = rsp_data;
    req_valid[id] = 1'b0;
    last_id = id;
  endtask

  task automatic expect_op(input string tag, input int id, input int op, input int addr,
                           input int wd, input int exp);
    logic [DW-1:0] r;
    do_op(id, op, addr, wd, r);
    chk(tag, 32'(r), 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 no rsp", 32'(rsp_valid), 0);
    chk("R1 no ready", 32'(req_ready), 0);
    expect_op("R1 word zero", 0, 0, 5, 0, 0);
    expect_op("R1 sc without ll", 3, 6, 6, 32'h77, 0);
    expect_op("R1 sc no write", 0, 0, 6, 0, 0);
  endtask

  task automatic t_rr;
    for (int i = 0; i < NREQ; i++) put(i, 0, 0, 0);
    for (int k = 0; k < NREQ; k++) begin
      int w;
      w = (last_id + 1) % NREQ;
      #1 chk("R2 rotation", 32'(req_ready), 32'(1 << w));
      @(negedge clk);
      chk("R3 rr rsp", 32'(rsp_valid), 32'(1 << w));
      req_valid[w] = 1'b0;
      last_id = w;
    end
  endtask

  task automatic t_contend;
    int w;
    int o;
    w = ((last_id + 1) % NREQ == 2) ? 2 : 1;
    o = 3 - w;
    put(1, 2, 2, 1);
    put(2, 2, 2, 1);
    #1 chk("R11 first grant", 32'(req_ready), 32'(1 << w));
    @(negedge clk);
    chk("R11 winner rsp", 32'(rsp_valid), 32'(1 << w));
    chk("R11 winner reads free", 32'(rsp_data), 0);
    req_valid[w] = 1'b0;
    #1 chk("R11 second grant", 32'(req_ready), 32'(1 << o));
    @(negedge clk);
    chk("R11 loser reads held", 32'(rsp_data), 1);
    req_valid[o] = 1'b0;
    last_id = o;
    expect_op("R4 lock release", o, 1, 2, 0, 0);
    expect_op("R4 released word", 0, 0, 2, 0, 0);
  endtask

  task automatic t_basic;
    expect_op("R4 store rsp", 1, 1, 3, 32'h1234, 0);
    expect_op("R4 load", 2, 0, 3, 32'hFFFF, 32'h1234);
    expect_op("R4 load no change", 0, 0, 3, 0, 32'h1234);
    expect_op("R5 swap old", 1, 2, 3, 32'hBEEF, 32'h1234);
    expect_op("R5 swap new", 0, 0, 3, 0, 32'hBEEF);
    expect_op("R6 tas free", 2, 3, 7, 0, 0);
    expect_op("R6 tas set", 0, 0, 7, 0, 1);
    expect_op("R6 tas held", 3, 3, 7, 0, 1);
    expect_op("R6 tas nonzero", 3, 3, 3, 0, 32'hBEEF);
    expect_op("R6 tas kept", 0, 0, 3, 0, 32'hBEEF);
    expect_op("R7 finc old", 1, 4, 8, 0, 0);
    expect_op("R7 finc new", 0, 0, 8, 0, 1);
    expect_op("R7 store max", 1, 1, 8, 32'hFFFF, 0);
    expect_op("R7 finc at max", 2, 4, 8, 0, 32'hFFFF);
    expect_op("R7 wrap", 0, 0, 8, 0, 0);
  endtask

  task automatic t_resv;
    expect_op("R8 ll value", 0, 5, 9, 0, 0);
    expect_op("R9 sc success", 0, 6, 9, 32'h55, 1);
    expect_op("R9 sc wrote", 1, 0, 9, 0, 32'h55);
    expect_op("R9 sc consumed", 0, 6, 9, 32'h66, 0);
    expect_op("R9 failed sc no write", 1, 0, 9, 0, 32'h55);
    expect_op("R10 ll r0", 0, 5, 10, 0, 0);
    expect_op("R10 ll r1", 1, 5, 10, 0, 0);
    expect_op("R10 other store", 2, 1, 10, 32'hA5, 0);
    expect_op("R10 r0 sc broken", 0, 6, 10, 32'h11, 0);
    expect_op("R10 r1 sc broken", 1, 6, 10, 32'h22, 0);
    expect_op("R10 store kept", 3, 0, 10, 0, 32'hA5);
    expect_op("R10 ll far", 0, 5, 11, 0, 0);
    expect_op("R10 write elsewhere", 1, 1, 12, 32'h9, 0);
    expect_op("R10 reservation kept", 0, 6, 11, 32'h3C, 1);
    expect_op("R8 ll first", 0, 5, 13, 0, 0);
    expect_op("R8 ll second", 0, 5, 14, 0, 0);
    expect_op("R8 replaced", 0, 6, 13, 32'h1, 0);
    expect_op("R8 ll r0 15", 0, 5, 15, 0, 0);
    expect_op("R8 ll r1 15", 1, 5, 15, 0, 0);
    expect_op("R10 sc clears peer win", 0, 6, 15, 32'h7, 1);
    expect_op("R10 sc clears peer", 1, 6, 15, 32'h8, 0);
    expect_op("R10 ll before finc", 2, 5, 4, 0, 0);
    expect_op("R10 finc", 3, 4, 4, 0, 0);
    expect_op("R10 finc breaks", 2, 6, 4, 32'h40, 0);
    expect_op("R10 ll before swap", 3, 5, 1, 0, 0);
    expect_op("R10 swap", 0, 2, 1, 32'h5, 0);
    expect_op("R10 swap breaks", 3, 6, 1, 32'h6, 0);
    expect_op("R10 ll before tas", 1, 5, 0, 0, 0);
    expect_op("R10 tas", 2, 3, 0, 0, 0);
    expect_op("R10 tas breaks", 1, 6, 0, 32'h9, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rr();
    t_contend();
    t_basic();
    t_resv();
    @(negedge clk);
    chk("R3 final idle", 32'(rsp_valid), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule